// File: doc/BRIEF.md
# Dual serial CRC accumulator

This block keeps two running CRC values side by side: one is fed by the bits a serial link receives, the other by the bits it sends. Each accumulator takes one data bit on each clock where its bit-valid strobe is high. Both use the same generator polynomial, which software programs into a 16-bit input. A frame-width input picks the CRC size. When it is high, the block runs a 16-bit CRC. When it is low, it runs an 8-bit CRC that uses only the low byte of the polynomial and of each accumulator.

Software starts a new CRC by writing 1 to the enable control. That write clears both accumulators, and from the next clock the accumulators take bits. Writing 0 stops all updates, and both results keep their values. The `busy` output is high on every clock where a bit is about to be folded into an accumulator. A result is stable and valid only on clocks where `busy` is low.

A small state machine holds the enable. It has two states:
- `ST_OFF`: updates blocked. This is the state after reset.
- `ST_ON`: updates allowed.

It has three named transitions:
- *arm*: `ST_OFF` to `ST_ON` on a write of 1.
- *rearm*: `ST_ON` to `ST_ON` on a write of 1, which clears both accumulators again.
- *disarm*: `ST_ON` to `ST_OFF` on a write of 0.

A write of 0 in `ST_OFF` leaves the state as it is.

Top module: `dual_crc_acc`

## Requirements
- R1: During reset and after it is released, `rx_crc` and `tx_crc` are 0x0000 and `busy` is 0, and the state machine is in `ST_OFF`.
- R2: A clock where `en_wr`=1 and `en_wdata`=1 leaves both `rx_crc` and `tx_crc` at 0x0000 on the following cycle, whatever their previous contents.
- R3: In `ST_OFF` (after reset, or from the clock after a write with `en_wdata`=0), bit strobes are ignored and both results hold. A write of 0 does not change either result.
- R4: With `wide_frame`=1, each accepted bit updates the accumulator MSB first. The next value is the accumulator shifted left by one. If bit 15 of the old value XOR the data bit is 1, the shifted value is also XORed with `poly[15:0]`.
- R5: With `wide_frame`=0, the feedback tap is bit 7 and only `poly[7:0]` is applied. Bits 15:8 of both results read as zero.
- R6: The RX accumulator changes only on clocks where `rx_bit_vld`=1, and the TX accumulator only on clocks where `tx_bit_vld`=1. Each one uses only its own data bit.
- R7: If an enable write of 1 and a bit strobe happen on the same clock, the clear wins and both results are 0x0000 on the next cycle.
- R8: `busy` is 1 exactly when the state is `ST_ON` and `rx_bit_vld` or `tx_bit_vld` is 1. On a clock where `busy` is 0 and no clear is written, neither result changes, as long as `wide_frame` is held steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Write strobe for the enable control |
| en_wdata | input | 1 | Value written: 1 clears and enables, 0 disables |
| poly | input | 16 | Generator polynomial (low byte only in 8-bit mode) |
| wide_frame | input | 1 | 1 selects 16-bit CRC, 0 selects 8-bit CRC |
| rx_bit | input | 1 | Received data bit |
| rx_bit_vld | input | 1 | Received bit is valid this clock |
| tx_bit | input | 1 | Transmitted data bit |
| tx_bit_vld | input | 1 | Transmitted bit is valid this clock |
| busy | output | 1 | An accumulator update is in progress this clock |
| rx_crc | output | 16 | RX accumulator result |
| tx_crc | output | 16 | TX accumulator result |

## Verification
Both accumulators are registered and drive the result ports directly, so a wrong feedback tap, a wrong polynomial mask or a lane that picks the wrong data bit shows at the result port on the clock after the bad bit. The error then stays there, because a CRC register never corrects itself. A wrong enable state shows in two ways on the same clock as a bit strobe: `busy` takes the wrong value, and on the next clock a result that should have held has changed, or one that should have changed has held. The bench runs every byte value in 8-bit mode and many words across several 16-bit polynomials, and compares each against an arithmetic model after every frame. This way each of these faults shows up within a few cycles of the stimulus that triggers it.

// File: rtl/dual_crc_pkg.sv
package dual_crc_pkg;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } crc_state_e;

    localparam int unsigned LANE_RX = 0;
    localparam int unsigned LANE_TX = 1;
    localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/dual_crc_ctrl.sv
module dual_crc_ctrl
    import dual_crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic rx_vld,
    input  logic tx_vld,
    output logic clr,
    output logic upd_rx,
    output logic upd_tx,
    output logic busy
);

    crc_state_e state_q;
    crc_state_e state_d;

    // next-state: arm, rearm, disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (en_wr && en_wdata) state_d = ST_ON;
            ST_ON:  if (en_wr && !en_wdata) state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs: clear has priority over any bit update (R7)
    always_comb begin
        clr    = en_wr & en_wdata;
        upd_rx = 1'b0;
        upd_tx = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_ON: begin
                upd_rx = rx_vld & ~clr;
                upd_tx = tx_vld & ~clr;
                busy   = rx_vld | tx_vld;
            end
        endcase
    end

endmodule

// File: rtl/dual_crc_lane.sv
module dual_crc_lane #(
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic              wide,
    input  logic              din,
    input  logic [WIDE_W-1:0] poly,
    output logic [WIDE_W-1:0] crc
);

    localparam logic [WIDE_W-1:0] NARROW_MASK =
        {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [WIDE_W-1:0] acc_q;
    logic [WIDE_W-1:0] acc_d;
    logic [WIDE_W-1:0] mask;
    logic [WIDE_W-1:0] shifted;
    logic              fb;

    always_comb begin
        mask    = wide ? {WIDE_W{1'b1}} : NARROW_MASK;
        fb      = (wide ? acc_q[WIDE_W-1] : acc_q[NARROW_W-1]) ^ din;
        shifted = (acc_q << 1) & mask;
        acc_d   = fb ? (shifted ^ (poly & mask)) : shifted;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (clr)   acc_q <= '0;
        else if (upd)   acc_q <= acc_d;
    end

    assign crc = acc_q & mask;

endmodule

// File: rtl/dual_crc_acc.sv
module dual_crc_acc
    import dual_crc_pkg::*;
#(
    parameter int unsigned CRC_W    = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic [CRC_W-1:0] poly,
    input  logic             wide_frame,
    input  logic             rx_bit,
    input  logic             rx_bit_vld,
    input  logic             tx_bit,
    input  logic             tx_bit_vld,
    output logic             busy,
    output logic [CRC_W-1:0] rx_crc,
    output logic [CRC_W-1:0] tx_crc
);

    logic                 clr;
    logic [NUM_LANES-1:0] upd;
    logic [NUM_LANES-1:0] din;
    logic [CRC_W-1:0]     res [NUM_LANES];

    dual_crc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .rx_vld   (rx_bit_vld),
        .tx_vld   (tx_bit_vld),
        .clr      (clr),
        .upd_rx   (upd[LANE_RX]),
        .upd_tx   (upd[LANE_TX]),
        .busy     (busy)
    );

    assign din[LANE_RX] = rx_bit;
    assign din[LANE_TX] = tx_bit;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dual_crc_lane #(
            .WIDE_W   (CRC_W),
            .NARROW_W (NARROW_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .upd   (upd[g]),
            .wide  (wide_frame),
            .din   (din[g]),
            .poly  (poly),
            .crc   (res[g])
        );
    end

    assign rx_crc = res[LANE_RX];
    assign tx_crc = res[LANE_TX];

endmodule

// File: rtl/dual_crc_acc_chk.sv
module dual_crc_acc_chk #(
    parameter int unsigned CRC_W    = 16,
    parameter int unsigned NARROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_wr,
    input logic             en_wdata,
    input logic [CRC_W-1:0] poly,
    input logic             wide_frame,
    input logic             rx_bit,
    input logic             rx_bit_vld,
    input logic             tx_bit,
    input logic             tx_bit_vld,
    input logic             busy,
    input logic [CRC_W-1:0] rx_crc,
    input logic [CRC_W-1:0] tx_crc
);

    localparam logic [CRC_W-1:0] LOW_MASK =
        {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic wr_one;
    assign wr_one = en_wr & en_wdata;

    // R1: results are zero right after reset release
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rx_crc == '0 && tx_crc == '0));

    // R2 / R7: an enable write of 1 clears both lanes
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_one |=> (rx_crc == '0 && tx_crc == '0));

    // R8: busy only when some bit strobe is present
    a_r8_busy_src: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rx_bit_vld || tx_bit_vld));

    // R8 / R3: no busy and no clear means both results hold
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_one) |=>
        (($stable(rx_crc) && $stable(tx_crc)) || (wide_frame != $past(wide_frame))));

    // R6: each lane moves only with its own strobe
    a_r6_rx_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_bit_vld && !wr_one) |=>
        ($stable(rx_crc) || (wide_frame != $past(wide_frame))));
    a_r6_tx_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_bit_vld && !wr_one) |=>
        ($stable(tx_crc) || (wide_frame != $past(wide_frame))));

    // R4: one wide step on the RX and TX lanes
    a_r4_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_frame && busy && rx_bit_vld && !wr_one) |=>
        (!wide_frame || rx_crc == (($past(rx_crc) << 1) ^
            (($past(rx_crc[CRC_W-1]) ^ $past(rx_bit)) ? $past(poly) : '0))));
    a_r4_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_frame && busy && tx_bit_vld && !wr_one) |=>
        (!wide_frame || tx_crc == (($past(tx_crc) << 1) ^
            (($past(tx_crc[CRC_W-1]) ^ $past(tx_bit)) ? $past(poly) : '0))));

    // R5: one narrow step, tap at the top of the low byte
    a_r5_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_frame && busy && rx_bit_vld && !wr_one) |=>
        (wide_frame || rx_crc == ((($past(rx_crc) << 1) & LOW_MASK) ^
            (($past(rx_crc[NARROW_W-1]) ^ $past(rx_bit)) ? ($past(poly) & LOW_MASK) : '0))));

endmodule

bind dual_crc_acc dual_crc_acc_chk #(
    .CRC_W    (CRC_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .poly       (poly),
    .wide_frame (wide_frame),
    .rx_bit     (rx_bit),
    .rx_bit_vld (rx_bit_vld),
    .tx_bit     (tx_bit),
    .tx_bit_vld (tx_bit_vld),
    .busy       (busy),
    .rx_crc     (rx_crc),
    .tx_crc     (tx_crc)
);

// File: tb/dual_crc_acc_test.sv
`timescale 1ns/1ps
module dual_crc_acc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 1'b0;
    logic        en_wdata = 1'b0;
    logic [15:0] poly = 16'h0;
    logic        wide_frame = 1'b1;
    logic        rx_bit = 1'b0;
    logic        rx_bit_vld = 1'b0;
    logic        tx_bit = 1'b0;
    logic        tx_bit_vld = 1'b0;
    logic        busy;
    logic [15:0] rx_crc;
    logic [15:0] tx_crc;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit          done = 1'b0;
    logic [15:0] m_rx;
    logic [15:0] m_tx;

    always #2.5 clk = ~clk;

    dual_crc_acc uut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .poly(poly), .wide_frame(wide_frame),
        .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .tx_bit(tx_bit), .tx_bit_vld(tx_bit_vld),
        .busy(busy), .rx_crc(rx_crc), .tx_crc(tx_crc)
    );

    // arithmetic model: polynomial division step over GF(2)
    function automatic logic [15:0] model_step(logic [15:0] a, logic b,
                                               logic [15:0] p, logic w);
        int unsigned width;
        int unsigned top;
        int unsigned modv;
        int unsigned v;
        width = w ? 16 : 8;
        modv  = 1 << width;
        top   = (a >> (width - 1)) & 1;
        v     = ((a % modv) * 2) % modv;
        if ((top ^ b) == 1) v = v ^ (p % modv);
        return v[15:0];
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_en(logic v);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0; en_wdata = 1'b0;
        if (v) begin m_rx = '0; m_tx = '0; end
    endtask

    // shift n bits MSB first; model follows only when enabled
    task automatic shift(logic [15:0] rw, logic [15:0] tw, int n,
                         logic ron, logic ton, logic enabled, string req);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            rx_bit = rw[i]; rx_bit_vld = ron;
            tx_bit = tw[i]; tx_bit_vld = ton;
            #1;
            check({req, "/R8 busy"}, {15'h0, busy}, {15'h0, enabled & (ron | ton)});
            if (enabled && ron) m_rx = model_step(m_rx, rw[i], poly, wide_frame);
            if (enabled && ton) m_tx = model_step(m_tx, tw[i], poly, wide_frame);
        end
        @(negedge clk);
        rx_bit_vld = 1'b0; tx_bit_vld = 1'b0;
        check({req, " rx"}, rx_crc, m_rx);
        check({req, " tx"}, tx_crc, m_tx);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] polys [5];
        logic [15:0] w1;
        logic [15:0] w2;
        logic [15:0] saved;
        polys[0] = 16'h8005; polys[1] = 16'h1021; polys[2] = 16'h3D65;
        polys[3] = 16'hC867; polys[4] = 16'h0589;
        m_rx = '0; m_tx = '0;

        repeat (3) @(negedge clk);
        check("R1 rx during reset", rx_crc, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rx", rx_crc, 16'h0);
        check("R1 tx", tx_crc, 16'h0);
        check("R1 busy", {15'h0, busy}, 16'h0);

        // R3: strobes ignored before any enable write
        poly = 16'h8005; wide_frame = 1'b1;
        shift(16'hFFFF, 16'hA5A5, 16, 1'b1, 1'b1, 1'b0, "R3 off after reset");

        // R4 / R6: wide sweep over polynomials and words
        for (int p = 0; p < 5; p++) begin
            poly = polys[p];
            write_en(1'b1);
            check("R2 rx cleared", rx_crc, 16'h0);
            for (int k = 0; k < 24; k++) begin
                w1 = 16'($urandom);
                w2 = 16'($urandom);
                shift(w1, w2, 16, 1'b1, 1'b1, 1'b1, "R4 wide word");
            end
        end

        // R6: only the RX lane strobes; TX must hold
        saved = m_tx;
        shift(16'h1234, 16'hFFFF, 16, 1'b1, 1'b0, 1'b1, "R6 rx only");
        check("R6 tx held", tx_crc, saved);
        saved = m_rx;
        shift(16'h0000, 16'h8001, 16, 1'b0, 1'b1, 1'b1, "R6 tx only");
        check("R6 rx held", rx_crc, saved);

        // R2: rearm clears nonzero contents
        write_en(1'b1);
        check("R2 rx rearm", rx_crc, 16'h0);
        check("R2 tx rearm", tx_crc, 16'h0);

        // R5: exhaustive narrow sweep, high polynomial byte must not leak
        wide_frame = 1'b0;
        poly = 16'hFF07;
        for (int b = 0; b < 256; b++) begin
            write_en(1'b1);
            shift(16'(b), 16'(b ^ 8'hFF), 8, 1'b1, 1'b1, 1'b1, "R5 narrow byte");
        end
        poly = 16'hAB31;
        write_en(1'b1);
        for (int k = 0; k < 16; k++)
            shift(16'($urandom), 16'($urandom), 8, 1'b1, 1'b1, 1'b1, "R5 narrow stream");
        check("R5 rx high byte zero", {8'h0, rx_crc[15:8]}, 16'h0);
        check("R5 tx high byte zero", {8'h0, tx_crc[15:8]}, 16'h0);

        // R7: clear and strobe on the same clock
        wide_frame = 1'b1;
        poly = 16'h8005;
        shift(16'hBEEF, 16'hCAFE, 16, 1'b1, 1'b1, 1'b1, "R7 preload");
        @(negedge clk);
        en_wr = 1'b1; en_wdata = 1'b1;
        rx_bit = 1'b1; rx_bit_vld = 1'b1; tx_bit = 1'b1; tx_bit_vld = 1'b1;
        @(negedge clk);
        en_wr = 1'b0; en_wdata = 1'b0; rx_bit_vld = 1'b0; tx_bit_vld = 1'b0;
        m_rx = '0; m_tx = '0;
        check("R7 rx clear wins", rx_crc, 16'h0);
        check("R7 tx clear wins", tx_crc, 16'h0);

        // R3: disarm holds results and ignores later strobes
        shift(16'h5A5A, 16'h0F0F, 16, 1'b1, 1'b1, 1'b1, "R3 before disarm");
        write_en(1'b0);
        check("R3 rx after write 0", rx_crc, m_rx);
        check("R3 tx after write 0", tx_crc, m_tx);
        shift(16'hFFFF, 16'h1357, 16, 1'b1, 1'b1, 1'b0, "R3 off after disarm");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule